// File: doc/BRIEF.md
# Bus Address Decoder for Parallel I/O Ports

This block sits between a processor bus and eight parallel I/O ports: four input sources and four output latches. Each cycle it looks at the 16-bit address, the read and write strobes and the I/O-or-memory select line. From these it works out whether the access goes to memory, to an I/O port, or nowhere. It raises a memory chip select for memory accesses. For I/O accesses it raises exactly one source output-enable (reads) or one latch-load strobe (writes). A selected source's byte appears on a multiplexed read-data output, which stands in for three-state drivers on a shared data bus.

A build-time parameter picks how I/O space is found. In the memory-mapped variant, I/O occupies the top kilobyte of the address space, and the whole address is compared so that no memory address can ever reach a port. In the separate-space variant, the select line alone marks I/O cycles, and only the two low address bits are examined. Each output latch captures write data on the clock edge ending a strobed cycle. Each latch also has its own synchronous clear.

Top module: `bus_io_decode`

## Requirements
- R1: With SEPARATE_IO=0, an access (rd or wr high) to address 0x0000..0xFBFF asserts mem_cs. An access to 0xFC00..0xFFFF leaves mem_cs low and is an I/O access. With neither strobe high, mem_cs is low.
- R2: With SEPARATE_IO=0, addresses 0xFBFC..0xFBFF assert no src_oe and no dst_ld bit, although their two low bits match a port, because all address bits are decoded.
- R3: During an I/O access, address bits [1:0] give the port number: value k selects bit k of src_oe or dst_ld.
- R4: src_oe[k] is high only during an I/O access with rd high and addr[1:0]==k.
- R5: dst_ld[k] is high only during an I/O access with wr high and addr[1:0]==k. At the next rising clock edge, latch k (dst_q bits [8k+7:8k]) takes wdata.
- R6: With SEPARATE_IO=1, io_sel high makes an access an I/O access whatever addr[15:2] holds. io_sel low makes it a memory access, which asserts mem_cs and no port signal.
- R7: mem_cs and any src_oe bit are never high in the same cycle.
- R8: At most one bit of src_oe, and at most one bit of dst_ld, is high in any cycle.
- R9: rdata equals source k's byte (src_data bits [8k+7:8k]) while src_oe[k] is high, and is zero when no src_oe bit is high.
- R10: dst_clr[k] high at a rising edge sets latch k to zero, and takes priority over a load in the same cycle. rst high at a rising edge clears all latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output latches |
| addr | input | 16 | Bus address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| io_sel | input | 1 | High for an I/O cycle, low for memory (used only when SEPARATE_IO=1) |
| wdata | input | 8 | Write data from the processor |
| src_data | input | 32 | Bytes offered by the four input sources, source k in bits [8k+7:8k] |
| dst_clr | input | 4 | Per-latch synchronous clear |
| mem_cs | output | 1 | Memory chip select |
| src_oe | output | 4 | One-hot-or-zero source output-enables |
| dst_ld | output | 4 | One-hot-or-zero latch-load strobes |
| rdata | output | 8 | Data returned to the processor |
| dst_q | output | 32 | Output latch contents, latch k in bits [8k+7:8k] |

## Verification
A decode fault shows in the same cycle on mem_cs, src_oe, dst_ld and rdata, since those paths hold no registers. A fault in the latch bank shows at the first sample after the clock edge that should have loaded or cleared the latch. The latched byte then stays wrong until that latch is next written. Window edges 0xFBFF/0xFC00 and the near-miss addresses just below the window show a partial decode immediately. Both variants are run side by side on identical stimulus, so a mode-dependent error stands out against the other instance.

// File: rtl/bio_pkg.sv
package bio_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_MEM  = 2'd1,
        CYC_IO   = 2'd2
    } cyc_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic io_sel;
    } bus_ctl_t;

    function automatic cyc_kind_e classify(input logic active, input logic io_hit);
        if (!active)
            return CYC_IDLE;
        return io_hit ? CYC_IO : CYC_MEM;
    endfunction

endpackage

// File: rtl/bio_space_decode.sv
module bio_space_decode
    import bio_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] IO_BASE     = 16'hFC00,
    parameter bit          SEPARATE_IO = 1'b0
) (
    input  logic [ADDR_W-1:0] addr,
    input  bus_ctl_t          ctl,
    output cyc_kind_e         kind
);

    logic io_hit;

    generate
        if (SEPARATE_IO) begin : g_sep
            logic [ADDR_W-1:0] unused_addr;
            assign unused_addr = addr;
            assign io_hit = ctl.io_sel;
        end else begin : g_map
            assign io_hit = (addr >= ADDR_W'(IO_BASE));
        end
    endgenerate

    assign kind = classify(ctl.rd | ctl.wr, io_hit);

endmodule

// File: rtl/bio_port_select.sv
module bio_port_select #(
    parameter int N_PORTS = 4,
    localparam int SEL_W  = $clog2(N_PORTS)
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic               rd_en,
    input  logic               wr_en,
    output logic [N_PORTS-1:0] oe,
    output logic [N_PORTS-1:0] ld
);

    generate
        for (genvar k = 0; k < N_PORTS; k++) begin : g_port
            logic hit;
            assign hit   = (sel == SEL_W'(k));
            assign oe[k] = hit & rd_en;
            assign ld[k] = hit & wr_en;
        end
    endgenerate

endmodule

// File: rtl/bio_latch_bank.sv
module bio_latch_bank #(
    parameter int N_PORTS = 4,
    parameter int DATA_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_PORTS-1:0]        clr,
    input  logic [N_PORTS-1:0]        ld,
    input  logic [DATA_W-1:0]         wdata,
    output logic [N_PORTS*DATA_W-1:0] q
);

    generate
        for (genvar k = 0; k < N_PORTS; k++) begin : g_lat
            logic [DATA_W-1:0] r;
            always_ff @(posedge clk) begin
                if (rst || clr[k])
                    r <= '0;
                else if (ld[k])
                    r <= wdata;
            end
            assign q[k*DATA_W +: DATA_W] = r;

            p_load_r5: assert property (@(posedge clk) disable iff (rst)
                (ld[k] && !clr[k]) |=> (q[k*DATA_W +: DATA_W] == $past(wdata)));
            p_clear_r10: assert property (@(posedge clk) disable iff (rst)
                clr[k] |=> (q[k*DATA_W +: DATA_W] == '0));
            p_hold_r5: assert property (@(posedge clk) disable iff (rst)
                (!ld[k] && !clr[k]) |=> $stable(q[k*DATA_W +: DATA_W]));
        end
    endgenerate

endmodule

// File: rtl/bus_io_decode.sv
module bus_io_decode
    import bio_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter int          DATA_W      = 8,
    parameter int          N_PORTS     = 4,
    parameter logic [15:0] IO_BASE     = 16'hFC00,
    parameter bit          SEPARATE_IO = 1'b0,
    localparam int         SEL_W       = $clog2(N_PORTS),
    localparam int         BUS_W       = N_PORTS * DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rd,
    input  logic               wr,
    input  logic               io_sel,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [BUS_W-1:0]   src_data,
    input  logic [N_PORTS-1:0] dst_clr,
    output logic               mem_cs,
    output logic [N_PORTS-1:0] src_oe,
    output logic [N_PORTS-1:0] dst_ld,
    output logic [DATA_W-1:0]  rdata,
    output logic [BUS_W-1:0]   dst_q
);

    bus_ctl_t  ctl;
    cyc_kind_e kind;
    logic      io_cyc;

    assign ctl = '{rd: rd, wr: wr, io_sel: io_sel};

    bio_space_decode #(
        .ADDR_W      (ADDR_W),
        .IO_BASE     (IO_BASE),
        .SEPARATE_IO (SEPARATE_IO)
    ) u_space (
        .addr (addr),
        .ctl  (ctl),
        .kind (kind)
    );

    assign io_cyc = (kind == CYC_IO);
    assign mem_cs = (kind == CYC_MEM);

    bio_port_select #(
        .N_PORTS (N_PORTS)
    ) u_sel (
        .sel   (addr[SEL_W-1:0]),
        .rd_en (io_cyc & rd),
        .wr_en (io_cyc & wr),
        .oe    (src_oe),
        .ld    (dst_ld)
    );

    bio_latch_bank #(
        .N_PORTS (N_PORTS),
        .DATA_W  (DATA_W)
    ) u_lat (
        .clk   (clk),
        .rst   (rst),
        .clr   (dst_clr),
        .ld    (dst_ld),
        .wdata (wdata),
        .q     (dst_q)
    );

    // Read path: OR of gated sources stands in for three-state drivers.
    always_comb begin
        rdata = '0;
        for (int k = 0; k < N_PORTS; k++)
            rdata |= src_oe[k] ? src_data[k*DATA_W +: DATA_W] : '0;
    end

    p_src_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_oe));
    p_dst_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dst_ld));
    p_no_conflict_r7: assert property (@(posedge clk) disable iff (rst)
        !(mem_cs && (|src_oe)));
    p_rd_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (|src_oe) |-> rd);
    p_wr_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (|dst_ld) |-> wr);
    p_idle_rdata_r9: assert property (@(posedge clk) disable iff (rst)
        !(|src_oe) |-> (rdata == '0));
    p_idle_cs_r1: assert property (@(posedge clk) disable iff (rst)
        !(rd || wr) |-> !mem_cs);

    generate
        if (!SEPARATE_IO) begin : g_map_chk
            p_window_r2: assert property (@(posedge clk) disable iff (rst)
                ((|src_oe) || (|dst_ld)) |-> (addr >= ADDR_W'(IO_BASE)));
        end
    endgenerate

endmodule

// File: tb/bus_io_decode_tb.sv
module bus_io_decode_tb;

    localparam int N  = 4;
    localparam int DW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic        rd = 1'b0, wr = 1'b0, io_sel = 1'b0;
    logic [7:0]  wdata = '0;
    logic [31:0] src_data = '0;
    logic [3:0]  dst_clr = '0;

    logic        cs_m, cs_s;
    logic [3:0]  oe_m, oe_s, ld_m, ld_s;
    logic [7:0]  rd_m, rd_s;
    logic [31:0] q_m, q_s;

    logic [31:0] mdl_m, mdl_s;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bus_io_decode #(.SEPARATE_IO(1'b0)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .io_sel(io_sel),
        .wdata(wdata), .src_data(src_data), .dst_clr(dst_clr),
        .mem_cs(cs_m), .src_oe(oe_m), .dst_ld(ld_m), .rdata(rd_m), .dst_q(q_m));

    bus_io_decode #(.SEPARATE_IO(1'b1)) u_dut_sep (
        .clk(clk), .rst(rst), .addr(addr), .rd(rd), .wr(wr), .io_sel(io_sel),
        .wdata(wdata), .src_data(src_data), .dst_clr(dst_clr),
        .mem_cs(cs_s), .src_oe(oe_s), .dst_ld(ld_s), .rdata(rd_s), .dst_q(q_s));

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit is_io(bit sep, logic [15:0] a, logic s);
        return sep ? s : (a >= 16'hFC00);
    endfunction

    function automatic logic [3:0] exp_oe(bit sep, logic [15:0] a, logic s, logic r);
        return (r && is_io(sep, a, s)) ? 4'(1 << a[1:0]) : 4'd0;
    endfunction

    function automatic logic exp_cs(bit sep, logic [15:0] a, logic s, logic r, logic w);
        return (r || w) && !is_io(sep, a, s);
    endfunction

    function automatic logic [7:0] exp_rd(logic [3:0] oe, logic [31:0] sd);
        logic [7:0] v = '0;
        for (int k = 0; k < N; k++)
            if (oe[k]) v = sd[k*DW +: DW];
        return v;
    endfunction

    function automatic logic [31:0] next_q(logic [31:0] cur, logic [3:0] ld,
                                           logic [3:0] clr, logic [7:0] d);
        logic [31:0] v = cur;
        for (int k = 0; k < N; k++) begin
            if (clr[k]) v[k*DW +: DW] = '0;
            else if (ld[k]) v[k*DW +: DW] = d;
        end
        return v;
    endfunction

    // One bus cycle: check latches from the previous edge, drive, check decode.
    task automatic step(logic [15:0] a, logic r, logic w, logic s,
                        logic [7:0] d, logic [3:0] clr, string tag);
        logic [3:0] eo_m, eo_s, el_m, el_s;
        @(negedge clk);
        chk("R5 R10", "dst_q map", q_m, mdl_m);
        chk("R5 R10 R6", "dst_q sep", q_s, mdl_s);
        addr = a; rd = r; wr = w; io_sel = s; wdata = d; dst_clr = clr;
        src_data = $urandom;
        #1;
        eo_m = exp_oe(1'b0, a, s, r);
        eo_s = exp_oe(1'b1, a, s, r);
        el_m = exp_oe(1'b0, a, s, w);
        el_s = exp_oe(1'b1, a, s, w);
        chk({"R1 ", tag}, "mem_cs map", 32'(cs_m), 32'(exp_cs(1'b0, a, s, r, w)));
        chk({"R3 R4 ", tag}, "src_oe map", 32'(oe_m), 32'(eo_m));
        chk({"R3 R5 ", tag}, "dst_ld map", 32'(ld_m), 32'(el_m));
        chk("R9", "rdata map", 32'(rd_m), 32'(exp_rd(eo_m, src_data)));
        chk("R6", "mem_cs sep", 32'(cs_s), 32'(exp_cs(1'b1, a, s, r, w)));
        chk("R6 R4", "src_oe sep", 32'(oe_s), 32'(eo_s));
        chk("R6 R5", "dst_ld sep", 32'(ld_s), 32'(el_s));
        chk("R9", "rdata sep", 32'(rd_s), 32'(exp_rd(eo_s, src_data)));
        chk("R7", "cs/oe overlap", 32'((cs_m && |oe_m) || (cs_s && |oe_s)), 32'd0);
        chk("R8", "oe/ld count",
            32'($countones(oe_m) > 1 || $countones(ld_m) > 1 ||
                $countones(oe_s) > 1 || $countones(ld_s) > 1), 32'd0);
        mdl_m = next_q(mdl_m, el_m, clr, d);
        mdl_s = next_q(mdl_s, el_s, clr, d);
    endtask

    initial begin
        void'($urandom(32'h1F00_C0DE));
        mdl_m = '0;
        mdl_s = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10", "reset q map", q_m, 32'd0);
        chk("R10", "reset q sep", q_s, 32'd0);
        chk("R1", "idle mem_cs", 32'(cs_m), 32'd0);
        rst = 1'b0;

        // Directed: window edges and near misses (R2)
        step(16'hFBFF, 1, 0, 0, 8'h00, 4'h0, "R2 edge-below");
        step(16'hFBFC, 0, 1, 1, 8'h11, 4'h0, "R2 near-miss");
        step(16'hFC00, 1, 0, 0, 8'h00, 4'h0, "window-low");
        step(16'hFFFF, 0, 1, 0, 8'hA5, 4'h0, "window-high");
        step(16'h0000, 1, 0, 1, 8'h00, 4'h0, "zero");
        step(16'hFC01, 0, 1, 1, 8'h3C, 4'h0, "write port1");
        step(16'hFC01, 0, 0, 0, 8'h00, 4'h0, "idle");
        // Clear beats load on the same port (R10)
        step(16'hFC02, 0, 1, 1, 8'h77, 4'h4, "R10 clr-vs-ld");
        step(16'hFC02, 0, 1, 1, 8'h88, 4'h0, "reload");
        step(16'hFC02, 0, 0, 0, 8'h00, 4'hF, "R10 clr-all");
        // Separate mode: high address with io_sel low is memory (R6)
        step(16'hFFFE, 1, 0, 0, 8'h00, 4'h0, "R6 io_sel-low");
        step(16'h1233, 1, 0, 1, 8'h00, 4'h0, "R6 upper-ignored");

        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic [2:0]  pick;
            pick = 3'($urandom);
            case (pick)
                3'd0, 3'd1: a = 16'hFC00 | 16'($urandom_range(0, 1023));
                3'd2:       a = 16'hFBFC | 16'($urandom_range(0, 7));
                default:    a = 16'($urandom);
            endcase
            step(a, 1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
                 ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0, "rand");
        end

        @(negedge clk);
        chk("R5 R10", "final q map", q_m, mdl_m);
        chk("R5 R10", "final q sep", q_s, mdl_s);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule